// File: doc/BRIEF.md
# Edge-to-Edge Cycle Measurement Controller

This block measures the time between two events in units of its own clock. A two-bit command, written through a one-cycle write strobe, starts a measurement in one of two start modes, cancels one in progress, or wipes the last result. Once armed, the block waits for the start event, counts clock cycles until the stop event shows an edge, and then holds that count with a completion flag. If the count reaches its top value first, the block keeps that value and also sets an overflow flag.

Both event inputs are asynchronous. Each passes through a two-flop synchroniser before the control logic uses it. A separate polarity bit for each event selects which level counts as active. The start can be level-qualified: counting begins as soon as the event is active. It can also be edge-qualified: the block first waits for the event to go inactive, then waits for it to become active again. The current control state is visible on an output so that software can tell when a command will be accepted.

Top module: `tdc_ctrl`

## Requirements
- R1: Command codes on `wr_cmd` when `wr_en` is high are: 3 = abort, 2 = level-start run, 1 = edge-start run, 0 = clear result. The `state` output encodes 0 = idle, 1 = counter clear, 2 = clear settle, 3 = wait for inactive start, 4 = armed, 5 = counting, 6 = finished.
- R2: A level-start run written in idle steps through states 1, 2 and 4. From state 4 the block enters state 5 in the cycle after the synchronised start is active, even if the start was already active when it was armed. A run also clears `done` and `sat`.
- R3: An edge-start run passes through state 3 instead of going directly to 4. The block stays in state 3 until the synchronised start is inactive, and only then waits in state 4 for it to become active.
- R4: In state 5, an inactive-to-active transition of the synchronised stop copies the cycle count into `result` and sets `done`. The block then goes through state 6 back to idle. The count is zero in the first counting cycle and rises by one each cycle after that.
- R5: If the count reaches its all-ones value in state 5 with no stop edge, it holds that value. In that case `result` takes the all-ones value and both `sat` and `done` are set.
- R6: Abort returns the block to idle from states 3, 4, 5 or 6 in the next cycle, and leaves `result`, `done` and `sat` unchanged.
- R7: Abort written in state 1 or 2 has no effect: the sequence continues as if no command had been written.
- R8: Clear written in idle sets `result` to zero and clears `done` and `sat`.
- R9: Any command other than abort is ignored outside idle. In particular, a clear during counting leaves the measurement running.
- R10: `start_pol` and `stop_pol` select the active level of each event (1 = high, 0 = low). A stop edge is a change from inactive to active.
- R11: After reset, `state` is 0, `result` is 0, and `done` and `sat` are low.
- R12: A change on an event input reaches the control logic after two clock edges. It affects `state` at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that is counted |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle command write strobe |
| wr_cmd | input | 2 | Command code |
| start_pol | input | 1 | Active level of the start event |
| stop_pol | input | 1 | Active level of the stop event |
| start_evt | input | 1 | Asynchronous start event |
| stop_evt | input | 1 | Asynchronous stop event |
| result | output | CNT_W | Last measured count |
| done | output | 1 | Measurement finished |
| sat | output | 1 | Count overflowed |
| state | output | 3 | Current control state |

## Verification
The assertions assume the following:
- `wr_cmd` is only meaningful while `wr_en` is high.
- The polarity bits stay constant for the whole of a measurement.
- Event inputs may change at any cycle, because they are synchronised first.

The stimulus changes polarity only in idle, after letting the synchronisers settle. It drives every input on the falling edge, and it applies each command for exactly one cycle. The one exception is the back-to-back run-then-abort pair that targets the clear states.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CLR  = 3'd1,
        ST_CLRW = 3'd2,
        ST_WOPP = 3'd3,
        ST_ARM  = 3'd4,
        ST_CNT  = 3'd5,
        ST_FIN  = 3'd6
    } tdc_state_e;

    typedef enum logic [1:0] {
        CMD_CLEAR = 2'd0,
        CMD_SRUN  = 2'd1,
        CMD_ARUN  = 2'd2,
        CMD_ABORT = 2'd3
    } tdc_cmd_e;
endpackage

// File: rtl/tdc_evt_sync.sv
module tdc_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol,
    output logic act,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], raw};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign act  = (sh_q[STAGES-1] == pol);
    assign rise = act && (sh_q[STAGES] != pol);
endmodule

// File: rtl/tdc_cycle_cnt.sv
module tdc_cycle_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         full
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (clr)                       val_d = '0;
        else if (inc && val_q != TOP)  val_d = val_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign val  = val_q;
    assign full = (val_q == TOP);

    // R5
    hold_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clr) |=> $stable(val_q));
endmodule

// File: rtl/tdc_ctrl.sv
module tdc_ctrl #(
    parameter int CNT_W = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_cmd,
    input  logic             start_pol,
    input  logic             stop_pol,
    input  logic             start_evt,
    input  logic             stop_evt,
    output logic [CNT_W-1:0] result,
    output logic             done,
    output logic             sat,
    output logic [2:0]       state
);
    import tdc_pkg::*;

    typedef struct packed {
        tdc_state_e       st;
        logic             edge_mode;
        logic [CNT_W-1:0] res;
        logic             done;
        logic             sat;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             start_act, start_rise_unused;
    logic             stop_act_unused, stop_rise;
    logic             cnt_clr, cnt_inc, cnt_full;
    logic [CNT_W-1:0] cnt_val;
    tdc_cmd_e         cmd;
    logic             abort_req;

    tdc_evt_sync #(.STAGES(SYNC_STAGES)) start_sync_i (
        .clk(clk), .rst_n(rst_n), .raw(start_evt), .pol(start_pol),
        .act(start_act), .rise(start_rise_unused)
    );

    tdc_evt_sync #(.STAGES(SYNC_STAGES)) stop_sync_i (
        .clk(clk), .rst_n(rst_n), .raw(stop_evt), .pol(stop_pol),
        .act(stop_act_unused), .rise(stop_rise)
    );

    tdc_cycle_cnt #(.W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .val(cnt_val), .full(cnt_full)
    );

    assign cmd       = tdc_cmd_e'(wr_cmd);
    assign abort_req = wr_en && (cmd == CMD_ABORT);

    always_comb begin
        r_d     = r_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (wr_en) begin
                    case (cmd)
                        CMD_ARUN, CMD_SRUN: begin
                            r_d.st        = ST_CLR;
                            r_d.edge_mode = (cmd == CMD_SRUN);
                            r_d.done      = 1'b0;
                            r_d.sat       = 1'b0;
                        end
                        CMD_CLEAR: begin
                            r_d.res  = '0;
                            r_d.done = 1'b0;
                            r_d.sat  = 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
            ST_CLR: begin
                cnt_clr = 1'b1;
                r_d.st  = ST_CLRW;
            end
            ST_CLRW: r_d.st = r_q.edge_mode ? ST_WOPP : ST_ARM;
            ST_WOPP: begin
                if (abort_req)       r_d.st = ST_IDLE;
                else if (!start_act) r_d.st = ST_ARM;
            end
            ST_ARM: begin
                if (abort_req)      r_d.st = ST_IDLE;
                else if (start_act) r_d.st = ST_CNT;
            end
            ST_CNT: begin
                if (abort_req) begin
                    r_d.st = ST_IDLE;
                end else if (stop_rise || cnt_full) begin
                    r_d.st   = ST_FIN;
                    r_d.res  = cnt_val;
                    r_d.done = 1'b1;
                    r_d.sat  = !stop_rise;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, edge_mode: 1'b0, res: '0, done: 1'b0, sat: 1'b0};
        else        r_q <= r_d;
    end

    assign result = r_q.res;
    assign done   = r_q.done;
    assign sat    = r_q.sat;
    assign state  = r_q.st;

    // R7
    clr_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CLR) |=> (r_q.st == ST_CLRW));

    // R7
    settle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CLRW) |=> (r_q.st == ST_WOPP || r_q.st == ST_ARM));

    // R5
    sat_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.sat |-> r_q.done);

    // R4
    done_from_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.done) |-> ($past(r_q.st) == ST_CNT));

    // R6
    abort_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && r_q.st inside {ST_WOPP, ST_ARM, ST_CNT, ST_FIN})
        |=> (r_q.st == ST_IDLE && $stable(r_q.res)));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st inside {ST_CLR, ST_CLRW, ST_WOPP, ST_ARM}) |=> $stable(r_q.res));
endmodule

// File: tb/tdc_ctrl_tb.sv
module tdc_ctrl_tb_top;
    localparam int CW  = 8;
    localparam int TOP = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_cmd = 2'd0;
    logic          start_pol = 1'b1, stop_pol = 1'b1;
    logic          start_evt = 1'b0, stop_evt = 1'b0;
    logic [CW-1:0] result;
    logic          done, sat;
    logic [2:0]    state;

    int n_vec = 0, n_bad = 0;
    string cur_req = "R11";

    always #5 clk = ~clk;

    tdc_ctrl #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .start_pol(start_pol), .stop_pol(stop_pol),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .result(result), .done(done), .sat(sat), .state(state)
    );

    // behavioural reference
    int m_st = 0, m_edge = 0, m_res = 0, m_done = 0, m_sat = 0, m_cnt = 0;
    int sa[3] = '{0, 0, 0};
    int sp[3] = '{0, 0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_edge = 0; m_res = 0; m_done = 0; m_sat = 0; m_cnt = 0;
            sa = '{0, 0, 0}; sp = '{0, 0, 0};
        end else begin
            bit s_on, p_hit, ab;
            s_on  = (sa[1] == int'(start_pol));
            p_hit = (sp[1] == int'(stop_pol)) && (sp[2] != int'(stop_pol));
            ab    = wr_en && wr_cmd == 2'd3;
            if (m_st == 0) begin
                if (wr_en && (wr_cmd == 2'd1 || wr_cmd == 2'd2)) begin
                    m_st = 1; m_edge = (wr_cmd == 2'd1); m_done = 0; m_sat = 0;
                end else if (wr_en && wr_cmd == 2'd0) begin
                    m_res = 0; m_done = 0; m_sat = 0;
                end
            end else if (m_st == 1) begin
                m_cnt = 0; m_st = 2;
            end else if (m_st == 2) begin
                m_st = m_edge ? 3 : 4;
            end else if (ab) begin
                m_st = 0;
            end else if (m_st == 3) begin
                if (!s_on) m_st = 4;
            end else if (m_st == 4) begin
                if (s_on) m_st = 5;
            end else if (m_st == 5) begin
                if (p_hit) begin
                    m_res = m_cnt; m_done = 1; m_st = 6;
                end else if (m_cnt == TOP) begin
                    m_res = m_cnt; m_done = 1; m_sat = 1; m_st = 6;
                end else begin
                    m_cnt++;
                end
            end else begin
                m_st = 0;
            end
            sa[2] = sa[1]; sa[1] = sa[0]; sa[0] = start_evt;
            sp[2] = sp[1]; sp[1] = sp[0]; sp[0] = stop_evt;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "state",  int'(state),  m_st);
            chk(cur_req, "result", int'(result), m_res);
            chk(cur_req, "done",   int'(done),   m_done);
            chk(cur_req, "sat",    int'(sat),    m_sat);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(logic [1:0] c);
        @(negedge clk);
        wr_en = 1'b1; wr_cmd = c;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic stop_pulse();
        stop_evt = stop_pol;
        cyc(3);
        stop_evt = ~stop_pol;
        cyc(6);
    endtask

    initial begin
        int saved;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R11 reset values
        chk("R11", "state", int'(state), 0);
        chk("R11", "result", int'(result), 0);
        chk("R11", "done", int'(done), 0);

        // R2 level start already active, R4 stop edge
        cur_req = "R2";
        start_evt = 1'b1; cyc(4);
        put(2'd2); cyc(4);
        chk("R2", "state", int'(state), 5);
        cur_req = "R4";
        cyc(6); stop_pulse();
        chk("R4", "done", int'(done), 1);
        chk("R4", "state", int'(state), 0);

        // R12 sync latency in armed state
        cur_req = "R12";
        start_evt = 1'b0; cyc(4);
        put(2'd2); cyc(5);
        chk("R12", "state", int'(state), 4);
        start_evt = 1'b1; cyc(2);
        chk("R12", "state", int'(state), 4);
        cyc(1);
        chk("R12", "state", int'(state), 5);
        stop_pulse();

        // R3 edge start waits for inactive first
        cur_req = "R3";
        put(2'd1); cyc(8);
        chk("R3", "state", int'(state), 3);
        start_evt = 1'b0; cyc(5);
        chk("R3", "state", int'(state), 4);
        start_evt = 1'b1; cyc(5);
        chk("R3", "state", int'(state), 5);
        stop_pulse();

        // R10 inverted polarities
        cur_req = "R10";
        start_pol = 1'b0; stop_pol = 1'b0; stop_evt = 1'b1; start_evt = 1'b1;
        cyc(5);
        put(2'd2); cyc(5);
        chk("R10", "state", int'(state), 4);
        start_evt = 1'b0; cyc(5);
        chk("R10", "state", int'(state), 5);
        stop_pulse();
        chk("R10", "done", int'(done), 1);
        start_pol = 1'b1; stop_pol = 1'b1; stop_evt = 1'b0; start_evt = 1'b1;
        cyc(5);

        // R9 clear ignored while counting
        cur_req = "R9";
        put(2'd2); cyc(6);
        put(2'd0);
        chk("R9", "state", int'(state), 5);
        cyc(4); stop_pulse();
        chk("R9", "done", int'(done), 1);

        // R6 abort during counting and while armed
        cur_req = "R6";
        saved = int'(result);
        put(2'd2); cyc(8);
        put(2'd3);
        chk("R6", "state", int'(state), 0);
        chk("R6", "result", int'(result), saved);
        start_evt = 1'b0; cyc(4);
        put(2'd2); cyc(6);
        put(2'd3);
        chk("R6", "state", int'(state), 0);
        start_evt = 1'b1; cyc(4);

        // R7 abort in clear state ignored
        cur_req = "R7";
        @(negedge clk); wr_en = 1'b1; wr_cmd = 2'd2;
        @(negedge clk); wr_cmd = 2'd3;
        @(negedge clk); wr_en = 1'b0;
        chk("R7", "state", int'(state), 2);
        cyc(2);
        chk("R7", "state", int'(state), 5);
        put(2'd3);

        // R5 saturation
        cur_req = "R5";
        put(2'd2); cyc(TOP + 20);
        chk("R5", "sat", int'(sat), 1);
        chk("R5", "result", int'(result), TOP);
        chk("R5", "done", int'(done), 1);

        // R8 clear in idle
        cur_req = "R8";
        put(2'd0); cyc(1);
        chk("R8", "result", int'(result), 0);
        chk("R8", "sat", int'(sat), 0);

        // R1 every command code once more
        cur_req = "R1";
        put(2'd1); cyc(3);
        chk("R1", "state", int'(state), 3);
        put(2'd3);
        chk("R1", "state", int'(state), 0);
        cyc(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule